// File: doc/BRIEF.md
# Read-Priority Write Buffer

This block sits between a write-through cache and main memory. Processor stores are queued as address and data pairs, so the processor goes on while the stores wait. Queued stores leave for memory one at a time, oldest first, and only in cycles when no read is waiting or in flight.

Reads always win the single memory request port. Each read address is compared against every store still in the queue. When one or more queued stores match, the data of the most recently queued match is returned one cycle later and memory is not touched. When nothing matches, the read goes to memory and the memory reply is passed straight back to the reader.

A read sees every store accepted in an earlier cycle. A store accepted in the same cycle as the read is not visible to that read.

Top module: `wrbuf_rdprio`

## Requirements
- R1: After reset the queue is empty. `wr_ready` is 1, and `mem_req_valid`, `rd_ready` and `rd_rsp_valid` are all 0.
- R2: A store is accepted (`wr_valid` and `wr_ready` both 1) while fewer than DEPTH (4) stores are queued. With DEPTH stores queued, `wr_ready` is 0.
- R3: While `rd_valid` is 1, any memory request shown is a read (`mem_req_write` = 0) and carries `rd_addr`, even when stores are queued.
- R4: A drain (`mem_req_write` = 1) is shown only when `rd_valid` is 0 and no memory read is awaiting its reply. In such a cycle a non-empty queue always shows a drain.
- R5: Drains leave in acceptance order, and each carries the address and data of the oldest queued store. Two stores to the same address are kept as two entries and both are drained.
- R6: A read whose address matches a queued store is accepted in the cycle it is presented, whatever the memory ready is. No memory request is made in that cycle. In the next cycle `rd_rsp_valid` is 1, and `rd_rsp_data` holds the data of the youngest matching store.
- R7: A read that misses the queue is accepted when memory accepts its request (`rd_ready` follows `mem_req_ready`). `rd_rsp_valid` and `rd_rsp_data` then follow `mem_rsp_valid` and `mem_rsp_data` in the same cycle. No new read is accepted while the reply is awaited.
- R8: Only stores still in the queue are compared. A read to an address whose stores have all drained goes to memory and returns the drained value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Queue can take a store |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | ADDR_W | Read address |
| rd_rsp_valid | output | 1 | Read data valid |
| rd_rsp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a drain, 0 for a read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_data | output | DATA_W | Drain data (0 for reads) |
| mem_rsp_valid | input | 1 | Memory read reply valid |
| mem_rsp_data | input | DATA_W | Memory read reply data |

## Verification
Directed cases cover four situations:
- A full queue holding repeated stores to one address. A read to that address tells youngest-match forwarding apart from oldest-match forwarding or a memory fetch.
- A missing read held against a memory that is not ready. This shows that reads keep the port and drains wait.
- A drain sequence with the reader idle. This checks first-in first-out order, including duplicate addresses.
- A read after the matching stores have drained. This separates comparison against live entries from comparison against stale slots.

A long random phase then mixes stores, reads over a small address set and a randomly stalling memory. Every reply is checked against a shadow of the last accepted store to each address.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;

    localparam int unsigned WB_ADDR_W = 16;
    localparam int unsigned WB_DATA_W = 32;
    localparam int unsigned WB_DEPTH  = 4;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_e;

endpackage

// File: rtl/wrbuf_store.sv
module wrbuf_store #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t            slot_q [DEPTH];
    logic [PTR_W-1:0]  wptr_q, rptr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign head_addr = slot_q[rptr_q].addr;
    assign head_data = slot_q[rptr_q].data;

    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wptr_q] <= '{addr: push_addr, data: push_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wptr_q <= bump(wptr_q);
            if (pop)  rptr_q <= bump(rptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Walk entries from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        logic [PTR_W-1:0] idx;
        look_hit  = 1'b0;
        look_data = '0;
        idx       = rptr_q;
        for (int k = 0; k < DEPTH; k++) begin
            if ((CNT_W'(k) < cnt_q) && (slot_q[idx].addr == look_addr)) begin
                look_hit  = 1'b1;
                look_data = slot_q[idx].data;
            end
            idx = bump(idx);
        end
    end

    // R2: occupancy never exceeds the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R2: an accepted store grows the queue by one
    p_push_grow_r2: assert property (@(posedge clk) disable iff (rst)
        push && !pop |=> cnt_q == $past(cnt_q) + 1'b1);

    // R5: a drain only removes an existing entry
    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> cnt_q != '0);

endmodule

// File: rtl/wrbuf_port.sv
module wrbuf_port
    import wrbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_rsp_valid,
    output logic [DATA_W-1:0] rd_rsp_data,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    input  logic              empty,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              pop,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    rd_state_e         state_q;
    logic              fwd_q;
    logic [DATA_W-1:0] fwd_data_q;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = rd_addr;
        mem_req_data  = '0;
        rd_ready      = 1'b0;
        pop           = 1'b0;
        if (state_q == RD_IDLE) begin
            if (rd_valid) begin
                if (look_hit) begin
                    rd_ready = 1'b1;
                end else begin
                    mem_req_valid = 1'b1;
                    rd_ready      = mem_req_ready;
                end
            end else if (!empty) begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = head_addr;
                mem_req_data  = head_data;
                pop           = mem_req_ready;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RD_IDLE;
            fwd_q      <= 1'b0;
            fwd_data_q <= '0;
        end else begin
            fwd_q <= (state_q == RD_IDLE) && rd_valid && look_hit;
            if ((state_q == RD_IDLE) && rd_valid && look_hit) begin
                fwd_data_q <= look_data;
            end
            case (state_q)
                RD_IDLE: if (rd_valid && !look_hit && mem_req_ready) state_q <= RD_WAIT;
                RD_WAIT: if (mem_rsp_valid) state_q <= RD_IDLE;
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign rd_rsp_valid = fwd_q || ((state_q == RD_WAIT) && mem_rsp_valid);
    assign rd_rsp_data  = fwd_q ? fwd_data_q : mem_rsp_data;

    // R3: a waiting read owns the memory port
    p_read_prio_r3: assert property (@(posedge clk) disable iff (rst)
        rd_valid && mem_req_valid |-> !mem_req_write);

    // R4: drains only while no read is waiting or in flight
    p_drain_idle_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write |-> !rd_valid && state_q == RD_IDLE);

    // R6: a hit never reaches memory
    p_hit_no_mem_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == RD_IDLE && rd_valid && look_hit |-> !mem_req_valid);

    // R6: forwarded data appears one cycle after the hit
    p_fwd_rsp_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == RD_IDLE && rd_valid && look_hit |=> rd_rsp_valid && rd_rsp_data == $past(look_data));

    // R7: no new read accepted while a memory reply is awaited
    p_wait_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        state_q == RD_WAIT |-> !rd_ready);

endmodule

// File: rtl/wrbuf_rdprio.sv
module wrbuf_rdprio
    import wrbuf_pkg::*;
#(
    parameter int unsigned ADDR_W = WB_ADDR_W,
    parameter int unsigned DATA_W = WB_DATA_W,
    parameter int unsigned DEPTH  = WB_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_rsp_valid,
    output logic [DATA_W-1:0] rd_rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic              full, empty, push, pop, look_hit;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data, look_data;

    assign wr_ready = !full;
    assign push     = wr_valid && !full;

    wrbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (pop),
        .head_addr (head_addr),
        .head_data (head_data),
        .empty     (empty),
        .full      (full),
        .look_addr (rd_addr),
        .look_hit  (look_hit),
        .look_data (look_data)
    );

    wrbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk           (clk),
        .rst           (rst),
        .rd_valid      (rd_valid),
        .rd_ready      (rd_ready),
        .rd_addr       (rd_addr),
        .rd_rsp_valid  (rd_rsp_valid),
        .rd_rsp_data   (rd_rsp_data),
        .look_hit      (look_hit),
        .look_data     (look_data),
        .empty         (empty),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .pop           (pop),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // R2: a full queue refuses stores
    p_full_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

endmodule

// File: tb/tb_wrbuf_rdprio.sv
module tb_wrbuf_rdprio;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam int WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, rd_ready, rd_rsp_valid;
    logic [DW-1:0] rd_rsp_data;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    wrbuf_rdprio dut (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int nchecks = 0, nfail = 0, cyc = 0;
    int mode = 1;
    logic [AW-1:0] qa[$];
    logic [DW-1:0] qd[$];
    logic [DW-1:0] bmem [16];
    logic [DW-1:0] shadow [16];
    bit rsp_pend = 0; int rsp_delay = 0; logic [DW-1:0] rsp_val = '0;
    bit rd_mem_out = 0;
    bit exp_pend = 0; logic [DW-1:0] exp_val = '0;
    bit fwd_expect = 0;
    bit wr_acc, rd_acc, rd_done;
    logic [DW-1:0] last_rsp = '0;

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hA500_0000 | DW'(a * 17);
    endfunction

    function automatic bit in_queue(input logic [AW-1:0] a);
        foreach (qa[i]) if (qa[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    endtask

    task automatic step();
        bit out_now, hit;
        @(negedge clk);
        if (mode == 0) mem_req_ready = 1'b0;
        else if (mode == 1) mem_req_ready = 1'b1;
        else mem_req_ready = 1'($urandom % 2);
        mem_rsp_valid = rsp_pend && (rsp_delay == 0);
        mem_rsp_data  = mem_rsp_valid ? rsp_val : '0;
        #1;
        wr_acc = 0; rd_acc = 0; rd_done = 0;
        out_now = rd_mem_out;
        if (fwd_expect) check(rd_rsp_valid, "R6 forward reply timing", DW'(rd_rsp_valid), 1);
        fwd_expect = 0;
        if (rd_rsp_valid) begin
            check(exp_pend, "R7 unexpected reply", DW'(rd_rsp_valid), 0);
            if (exp_pend) check(rd_rsp_data == exp_val, "R6/R7 reply data", rd_rsp_data, exp_val);
            exp_pend = 0; rd_done = 1; last_rsp = rd_rsp_data;
        end
        check(wr_ready == (qa.size() < DEPTH), "R2 wr_ready", DW'(wr_ready), DW'(qa.size() < DEPTH));
        if (out_now) check(!rd_ready, "R7 rd_ready while waiting", DW'(rd_ready), 0);
        if (mem_req_valid) begin
            if (rd_valid) check(!mem_req_write, "R3 read priority", DW'(mem_req_write), 0);
            if (mem_req_write) begin
                check(!rd_valid && !out_now, "R4 drain while read pending", DW'({rd_valid, out_now}), 0);
                if (mem_req_ready) begin
                    check(qa.size() > 0 && mem_req_addr == qa[0], "R5 drain address",
                          DW'(mem_req_addr), qa.size() > 0 ? DW'(qa[0]) : '0);
                    check(qa.size() > 0 && mem_req_data == qd[0], "R5 drain data",
                          mem_req_data, qd.size() > 0 ? qd[0] : '0);
                    bmem[mem_req_addr[3:0]] = mem_req_data;
                    if (qa.size() > 0) begin void'(qa.pop_front()); void'(qd.pop_front()); end
                end
            end else begin
                check(rd_valid && mem_req_addr == rd_addr, "R3 read address", DW'(mem_req_addr), DW'(rd_addr));
            end
        end else if (!rd_valid && !out_now && qa.size() > 0) begin
            check(1'b0, "R4 drain missing", 0, 1);
        end
        if (rd_valid && rd_ready) begin
            hit = in_queue(rd_addr);
            exp_pend = 1; exp_val = shadow[rd_addr[3:0]]; rd_acc = 1;
            if (hit) begin
                check(!mem_req_valid, "R6 hit touched memory", DW'(mem_req_valid), 0);
                fwd_expect = 1;
            end else begin
                check(mem_req_valid && !mem_req_write && mem_req_ready, "R8 miss goes to memory",
                      DW'({mem_req_valid, mem_req_write, mem_req_ready}), 3'b101);
            end
        end
        if (wr_valid && wr_ready) begin
            qa.push_back(wr_addr); qd.push_back(wr_data);
            shadow[wr_addr[3:0]] = wr_data; wr_acc = 1;
        end
        if (mem_rsp_valid) begin rsp_pend = 0; rd_mem_out = 0; end
        else if (rsp_pend && rsp_delay > 0) rsp_delay--;
        if (mem_req_valid && mem_req_ready && !mem_req_write) begin
            rsp_pend = 1; rd_mem_out = 1;
            rsp_delay = int'($urandom % 3);
            rsp_val = bmem[mem_req_addr[3:0]];
        end
        cyc++;
        if (cyc >= WD_LIMIT) begin
            nchecks++; nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        wr_valid = 1; wr_addr = AW'(a); wr_data = d;
        do step(); while (!wr_acc);
        wr_valid = 0;
    endtask

    task automatic do_read(input int a);
        rd_valid = 1; rd_addr = AW'(a);
        do step(); while (!rd_acc);
        rd_valid = 0;
        while (!rd_done) step();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin bmem[i] = init_val(i); shadow[i] = init_val(i); end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(wr_ready == 1'b1, "R1 reset wr_ready", DW'(wr_ready), 1);
        check(!mem_req_valid && !rd_ready && !rd_rsp_valid, "R1 reset outputs",
              DW'({mem_req_valid, rd_ready, rd_rsp_valid}), 0);
        @(posedge clk); #1;

        // R2, R5: fill with duplicates while memory stalls
        mode = 0;
        do_write(3, 32'h1); do_write(3, 32'h2); do_write(5, 32'h3); do_write(3, 32'h4);
        wr_valid = 1; wr_addr = AW'(9); wr_data = 32'h5;
        step();
        check(!wr_acc && !wr_ready, "R2 full refuses store", DW'(wr_ready), 0);
        wr_valid = 0;

        // R6: youngest matching store forwarded with memory stalled
        do_read(3);
        check(last_rsp == 32'h4, "R6 youngest match", last_rsp, 32'h4);

        // R3, R7: miss held while memory stalls, drains stay blocked
        rd_valid = 1; rd_addr = AW'(7);
        repeat (5) step();
        check(!rd_acc, "R7 miss waits for memory", DW'(rd_acc), 0);
        mode = 1;
        while (!rd_acc) step();
        rd_valid = 0;
        while (!rd_done) step();
        check(last_rsp == init_val(7), "R7 memory reply", last_rsp, init_val(7));

        // R5, R4: drain everything in order
        while (qa.size() > 0) step();
        check(bmem[3] == 32'h4, "R5 last duplicate lands", bmem[3], 32'h4);

        // R8: drained address now comes from memory
        do_read(3);
        check(last_rsp == 32'h4, "R8 read after drain", last_rsp, 32'h4);

        // random mix
        mode = 2;
        for (int n = 0; n < 4000; n++) begin
            if (!wr_valid && ($urandom % 3 == 0)) begin
                wr_valid = 1; wr_addr = AW'($urandom % 8); wr_data = $urandom;
            end
            if (!rd_valid && !exp_pend && !rd_mem_out && ($urandom % 4 == 0)) begin
                rd_valid = 1; rd_addr = AW'($urandom % 8);
            end
            step();
            if (wr_acc) wr_valid = 0;
            if (rd_acc) rd_valid = 0;
        end
        wr_valid = 0; rd_valid = 0; mode = 1;
        while (exp_pend || qa.size() > 0) step();
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end

endmodule